// File: doc/BRIEF.md
# Mesh Wormhole Router Node

This block is one router of a packet network laid out as a two-dimensional grid of compute tiles. It has five bidirectional ports: one toward the local processor and one toward each of the four neighbours (north, east, south, west). Every port carries 32-bit words in both directions. Each direction has its own valid/ready handshake, and each input port has a small FIFO.

A packet starts with a header word. The header gives the destination tile's X and Y coordinates and the number of payload words. The router first resolves X and then Y to choose an output. When an output is free, a round-robin arbiter grants it to one of the inputs that want it. The output then stays locked to that input until the header and all payload words have passed, so packets never interleave.

Each output link can be walled off by a static protection input. A packet whose header targets a walled output does not leave the router. Its header and payload are drained from the input FIFO and discarded, and a per-output interrupt pulse reports the blocked attempt.

Top module: `mesh_router`

## Requirements
- R1: After reset all outputs are invalid, every input is ready and every interrupt line is low.
- R2: Header layout: bits [3:0] hold destination X, bits [7:4] destination Y, bits [15:8] the payload length in words (0 to 128). Bits [31:16] are carried through unchanged. A destination X above the node's X goes out on east (port 2), and a destination X below it goes out on west (port 4).
- R3: When destination X equals the node's X, a larger Y goes to north (port 1) and a smaller Y goes to south (port 3). When both X and Y match, the packet goes to the local port (port 0).
- R4: On an unwalled path, the header and exactly the given number of payload words appear on the chosen output, unchanged and in order. No word is lost or duplicated.
- R5: Once an output is granted, it carries only the words of that one packet until the packet's last word has been transferred. Words of two packets never interleave on one output.
- R6: An output with several waiting inputs serves them in round-robin order, so no input is granted twice in a row while another input is still waiting.
- R7: While an output is valid and its ready is low, the valid stays high and the data stays unchanged.
- R8: Each input FIFO holds four words. Its ready goes low once four words are stored and none can leave.
- R9: A packet whose header targets a walled output is consumed in full (header and payload) and produces no word on any output. The next packet from the same input is routed normally.
- R10: A blocked header raises the interrupt line of the walled output for exactly one cycle. No other interrupt line rises.
- R11: The wall setting is examined only when a header is routed. Raising a wall in the middle of a packet does not cut that packet short and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_x_i | input | 4 | X coordinate of this tile |
| node_y_i | input | 4 | Y coordinate of this tile |
| in_valid_i | input | 5 | Word valid per input port (0 local, 1 north, 2 east, 3 south, 4 west) |
| in_data_i | input | 5x32 | Word per input port |
| in_ready_o | output | 5 | Input FIFO can accept a word |
| out_valid_o | output | 5 | Word valid per output port |
| out_data_o | output | 5x32 | Word per output port |
| out_ready_i | input | 5 | Downstream accepts the word |
| wall_i | input | 5 | Output link walled off |
| irq_o | output | 5 | One-cycle pulse when a packet is blocked at that output |

## Verification
The embedded properties assume that every header carries a length of at most 128, and that an input, once it has offered a word, keeps it offered until it is accepted. They also assume that each walled packet is the only blocked packet reaching its output in that cycle, so that one pulse stands for one packet. The stimulus builds every header from legal coordinates and lengths up to 128. Its driver holds valid and data until ready is seen. Blocked packets are issued one at a time, with the wall held steady from before the header until the drain is complete, except in the test that raises it deliberately after the header.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int NPORT = 5;

  typedef enum logic [2:0] {
    P_LOCAL = 3'd0,
    P_NORTH = 3'd1,
    P_EAST  = 3'd2,
    P_SOUTH = 3'd3,
    P_WEST  = 3'd4
  } port_e;

  typedef enum logic [1:0] {
    IN_IDLE = 2'd0,
    IN_FWD  = 2'd1,
    IN_DROP = 2'd2
  } in_state_e;
endpackage

// File: rtl/rtr_fifo.sv
module rtr_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic              full_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_q, rd_q;
  logic [CW-1:0]     cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> cnt_q < CW'(DEPTH));
  assert_count_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i |=> cnt_q == $past(cnt_q) + CW'(1));
  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> valid_o);
endmodule

// File: rtl/rtr_route.sv
module rtr_route
  import router_pkg::*;
#(
  parameter int COORD_W = 4,
  parameter int PW      = 3
) (
  input  logic [COORD_W-1:0] dst_x_i,
  input  logic [COORD_W-1:0] dst_y_i,
  input  logic [COORD_W-1:0] node_x_i,
  input  logic [COORD_W-1:0] node_y_i,
  output logic [PW-1:0]      port_o
);
  // X first, then Y
  always_comb begin
    if (dst_x_i > node_x_i)      port_o = PW'(P_EAST);
    else if (dst_x_i < node_x_i) port_o = PW'(P_WEST);
    else if (dst_y_i > node_y_i) port_o = PW'(P_NORTH);
    else if (dst_y_i < node_y_i) port_o = PW'(P_SOUTH);
    else                         port_o = PW'(P_LOCAL);
  end
endmodule

// File: rtl/rtr_rr_arb.sv
module rtr_rr_arb #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q, win;
  logic          hit;

  // search starts one past the last winner
  always_comb begin
    gnt_o = '0;
    win   = last_q;
    hit   = 1'b0;
    for (int k = 1; k <= N; k++) begin
      if (!hit && req_i[(int'(last_q) + k) % N]) begin
        hit = 1'b1;
        gnt_o[(int'(last_q) + k) % N] = 1'b1;
        win = IW'((int'(last_q) + k) % N);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  last_q <= IW'(N - 1);
    else if (hit) last_q <= win;
  end

  assert_gnt_from_ptr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && req_i[last_q] && $countones(req_i) > 1 |-> !gnt_o[last_q]);
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import router_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int COORD_W    = 4,
  parameter int LEN_W      = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [COORD_W-1:0]             node_x_i,
  input  logic [COORD_W-1:0]             node_y_i,
  input  logic [NPORT-1:0]               in_valid_i,
  input  logic [NPORT-1:0][DATA_W-1:0]   in_data_i,
  output logic [NPORT-1:0]               in_ready_o,
  output logic [NPORT-1:0]               out_valid_o,
  output logic [NPORT-1:0][DATA_W-1:0]   out_data_o,
  input  logic [NPORT-1:0]               out_ready_i,
  input  logic [NPORT-1:0]               wall_i,
  output logic [NPORT-1:0]               irq_o
);
  localparam int PW    = $clog2(NPORT);
  localparam int CNT_W = LEN_W + 1;
  localparam int LEN_LO = 2 * COORD_W;

  logic [NPORT-1:0]             f_vld, f_full, f_pop, push;
  logic [NPORT-1:0][DATA_W-1:0] f_data;
  logic [NPORT-1:0][PW-1:0]     rt, tgt, owner, gnt_idx;
  logic [NPORT-1:0][CNT_W-1:0]  rem;
  in_state_e                    st [NPORT];
  logic [NPORT-1:0]             busy, rel, drop_start, granted, last_pop, owned_by, blk_hit, irq_q;
  logic [NPORT-1:0][NPORT-1:0]  req, gnt;  // [output][input]

  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      gnt_idx[o] = '0;
      blk_hit[o] = 1'b0;
      for (int i = 0; i < NPORT; i++) begin
        req[o][i] = (st[i] == IN_IDLE) && f_vld[i] && (rt[i] == PW'(o))
                    && !wall_i[o] && !busy[o];
        if (gnt[o][i]) gnt_idx[o] = PW'(i);
        if (drop_start[i] && rt[i] == PW'(o)) blk_hit[o] = 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      granted[i]  = 1'b0;
      owned_by[i] = 1'b0;
      for (int o = 0; o < NPORT; o++) begin
        if (gnt[o][i]) granted[i] = 1'b1;
        if (busy[o] && owner[o] == PW'(i)) owned_by[i] = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    logic [LEN_W-1:0] hdr_len;

    assign push[i]       = in_valid_i[i] & ~f_full[i];
    assign in_ready_o[i] = ~f_full[i];
    assign hdr_len       = f_data[i][LEN_LO +: LEN_W];

    rtr_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[i]),
      .data_i  (in_data_i[i]),
      .pop_i   (f_pop[i]),
      .full_o  (f_full[i]),
      .valid_o (f_vld[i]),
      .data_o  (f_data[i])
    );

    rtr_route #(.COORD_W(COORD_W), .PW(PW)) u_route (
      .dst_x_i  (f_data[i][COORD_W-1:0]),
      .dst_y_i  (f_data[i][2*COORD_W-1:COORD_W]),
      .node_x_i (node_x_i),
      .node_y_i (node_y_i),
      .port_o   (rt[i])
    );

    // wall is looked at only while the header waits at the FIFO head
    assign drop_start[i] = (st[i] == IN_IDLE) && f_vld[i] && wall_i[rt[i]];
    assign f_pop[i]      = f_vld[i] && (((st[i] == IN_FWD) && out_ready_i[tgt[i]])
                                        || (st[i] == IN_DROP));
    assign last_pop[i]   = f_pop[i] && (rem[i] == CNT_W'(1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st[i]  <= IN_IDLE;
        tgt[i] <= '0;
        rem[i] <= '0;
      end else if (st[i] == IN_IDLE) begin
        if (drop_start[i]) begin
          st[i]  <= IN_DROP;
          rem[i] <= CNT_W'(hdr_len) + CNT_W'(1);
        end else if (granted[i]) begin
          st[i]  <= IN_FWD;
          tgt[i] <= rt[i];
          rem[i] <= CNT_W'(hdr_len) + CNT_W'(1);
        end
      end else if (f_pop[i]) begin
        rem[i] <= rem[i] - CNT_W'(1);
        if (last_pop[i]) st[i] <= IN_IDLE;
      end
    end

    assert_lock_owner_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st[i] == IN_FWD |-> busy[tgt[i]] && owner[tgt[i]] == PW'(i));
    assert_drop_silent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st[i] == IN_DROP |-> !owned_by[i]);
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    rtr_rr_arb #(.N(NPORT)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req[o]),
      .gnt_o  (gnt[o])
    );

    assign rel[o] = busy[o] && last_pop[owner[o]] && (st[owner[o]] == IN_FWD);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy[o]  <= 1'b0;
        owner[o] <= '0;
        irq_q[o] <= 1'b0;
      end else begin
        irq_q[o] <= blk_hit[o];
        if (|gnt[o]) begin
          busy[o]  <= 1'b1;
          owner[o] <= gnt_idx[o];
        end else if (rel[o]) begin
          busy[o] <= 1'b0;
        end
      end
    end

    assign out_valid_o[o] = busy[o] & f_vld[owner[o]];
    assign out_data_o[o]  = f_data[owner[o]];
    assign irq_o[o]       = irq_q[o];

    assert_hold_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[o] && !out_ready_i[o] |=> out_valid_o[o] && $stable(out_data_o[o]));
    assert_owner_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy[o] && !rel[o] |=> busy[o] && $stable(owner[o]));
    assert_irq_walled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[o] |-> $past(wall_i[o]));
  end
endmodule

// File: tb/test_mesh_router.sv
module test_mesh_router;
  import router_pkg::*;

  localparam int NP = 5;
  localparam int DW = 32;
  localparam int DEPTH = 4;
  localparam int MX = 2;
  localparam int MY = 2;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic [NP-1:0]         in_valid, in_ready, out_valid, out_rdy, wall, irq;
  logic [NP-1:0][DW-1:0] in_data, out_data;

  mesh_router i_mesh_router (
    .clk_i(clk), .rst_ni(rst_n), .node_x_i(4'(MX)), .node_y_i(4'(MY)),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_rdy),
    .wall_i(wall), .irq_o(irq)
  );

  int n_checks = 0, n_fail = 0;
  logic [31:0] exp_q [NP*NP][$];
  int west_log[$];
  int irq_cnt[NP], irq_exp[NP], words_seen[NP], rdy_mode[NP], sent_words[NP];
  int mrem[NP], msrc[NP];
  logic prev_v[NP], prev_r[NP];
  logic [31:0] prev_d[NP];
  int seq_ctr = 0;
  string cur_req = "R4";

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  function automatic int route_of(input int dx, input int dy);
    if (dx > MX) return 2;
    if (dx < MX) return 4;
    if (dy > MY) return 1;
    if (dy < MY) return 3;
    return 0;
  endfunction

  task automatic put_word(input int src, input logic [31:0] w);
    in_valid[src] = 1'b1;
    in_data[src]  = w;
    while (!in_ready[src]) @(negedge clk);
    @(negedge clk);
    in_valid[src] = 1'b0;
    sent_words[src]++;
  endtask

  task automatic send_pkt(input int src, input int dx, input int dy, input int len, input bit blocked);
    int o;
    logic [31:0] w;
    o = route_of(dx, dy);
    w = {8'h00, 8'(src), 8'(len), 4'(dy), 4'(dx)};
    if (blocked) irq_exp[o]++;
    else exp_q[src*NP+o].push_back(w);
    put_word(src, w);
    for (int k = 0; k < len; k++) begin
      w = {4'hA, 4'(src), 24'(seq_ctr)};
      seq_ctr++;
      if (!blocked) exp_q[src*NP+o].push_back(w);
      put_word(src, w);
    end
  endtask

  function automatic bit all_empty();
    for (int q = 0; q < NP*NP; q++) if (exp_q[q].size() != 0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic drain();
    for (int t = 0; t < 4000; t++) begin
      if (all_empty()) break;
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  // output monitor and reference comparison, every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int o = 0; o < NP; o++) begin
        case (rdy_mode[o])
          0: out_rdy[o] = 1'b1;
          1: out_rdy[o] = 1'b0;
          default: out_rdy[o] = 1'($urandom_range(0, 1));
        endcase
        if (prev_v[o] && !prev_r[o]) begin
          check(out_valid[o] === 1'b1, "R7", "valid held", longint'(out_valid[o]), 1);
          check(out_data[o] === prev_d[o], "R7", "data held", longint'(out_data[o]), longint'(prev_d[o]));
        end
        if (out_valid[o] && out_rdy[o]) begin
          words_seen[o]++;
          if (mrem[o] == 0) begin
            int s;
            int dx;
            s  = int'(out_data[o][23:16]);
            dx = int'(out_data[o][3:0]);
            check(route_of(dx, int'(out_data[o][7:4])) == o, (dx != MX) ? "R2" : "R3",
                  "header port", o, route_of(dx, int'(out_data[o][7:4])));
            if (s < NP && exp_q[s*NP+o].size() > 0) begin
              check(out_data[o] === exp_q[s*NP+o][0], "R4", "header word",
                    longint'(out_data[o]), longint'(exp_q[s*NP+o][0]));
              void'(exp_q[s*NP+o].pop_front());
            end else begin
              check(1'b0, "R9", "unexpected header", longint'(out_data[o]), 0);
            end
            msrc[o] = (s < NP) ? s : 0;
            mrem[o] = int'(out_data[o][15:8]);
            if (o == 4) west_log.push_back(s);
          end else begin
            if (exp_q[msrc[o]*NP+o].size() > 0) begin
              check(out_data[o] === exp_q[msrc[o]*NP+o][0], cur_req, "payload word",
                    longint'(out_data[o]), longint'(exp_q[msrc[o]*NP+o][0]));
              void'(exp_q[msrc[o]*NP+o].pop_front());
            end else begin
              check(1'b0, cur_req, "extra payload", longint'(out_data[o]), 0);
            end
            mrem[o]--;
          end
        end
        if (irq[o]) irq_cnt[o]++;
        prev_v[o] = out_valid[o];
        prev_r[o] = out_rdy[o];
        prev_d[o] = out_data[o];
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL R4 watchdog expired: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int b0, b1;
    rst_n = 1'b0;
    in_valid = '0;
    in_data = '0;
    wall = '0;
    out_rdy = '0;
    for (int o = 0; o < NP; o++) begin
      irq_cnt[o] = 0; irq_exp[o] = 0; words_seen[o] = 0; rdy_mode[o] = 0;
      sent_words[o] = 0; mrem[o] = 0; msrc[o] = 0;
      prev_v[o] = 1'b0; prev_r[o] = 1'b0; prev_d[o] = '0;
    end
    repeat (3) @(negedge clk);
    check(out_valid === 5'h00, "R1", "out_valid after reset", longint'(out_valid), 0);
    check(in_ready === 5'h1f, "R1", "in_ready after reset", longint'(in_ready), 'h1f);
    check(irq === 5'h00, "R1", "irq after reset", longint'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3: each direction from the local port
    send_pkt(0, 3, 2, 2, 0);
    send_pkt(0, 0, 5, 2, 0);
    send_pkt(0, 2, 7, 2, 0);
    send_pkt(0, 2, 0, 2, 0);
    send_pkt(0, 2, 2, 2, 0);
    send_pkt(0, 7, 0, 1, 0);
    drain();

    // R4: concurrent mixed traffic, random backpressure
    for (int o = 0; o < NP; o++) rdy_mode[o] = 2;
    for (int s = 0; s < NP; s++) begin
      fork
        automatic int ss = s;
        begin
          for (int p = 0; p < 8; p++)
            send_pkt(ss, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 6), 0);
        end
      join_none
    end
    wait fork;
    drain();
    send_pkt(4, 2, 2, 128, 0);  // longest packet, R4 boundary
    send_pkt(4, 2, 2, 0, 0);    // header only
    drain();
    for (int o = 0; o < NP; o++) rdy_mode[o] = 0;

    // R5: two long packets contend for east
    cur_req = "R5";
    fork
      send_pkt(1, 6, 3, 10, 0);
      send_pkt(3, 6, 1, 10, 0);
    join
    drain();
    cur_req = "R4";

    // R6: three inputs queued for a stalled west output
    rdy_mode[4] = 1;
    west_log.delete();
    fork
      begin send_pkt(1, 0, 4, 1, 0); send_pkt(1, 1, 4, 1, 0); end
      begin send_pkt(3, 0, 0, 1, 0); send_pkt(3, 1, 0, 1, 0); end
      begin send_pkt(2, 0, 2, 1, 0); send_pkt(2, 1, 2, 1, 0); end
    join
    repeat (10) @(negedge clk);
    rdy_mode[4] = 0;
    drain();
    check(west_log.size() == 6, "R6", "west packet count", west_log.size(), 6);
    if (west_log.size() == 6) begin
      for (int k = 1; k < 6; k++)
        check(west_log[k] != west_log[k-1], "R6", "repeat grant", west_log[k], west_log[k-1]);
      for (int k = 3; k < 6; k++)
        check(west_log[k] == west_log[k-3], "R6", "rotation order", west_log[k], west_log[k-3]);
    end

    // R8 R7: stalled east output fills the local FIFO
    rdy_mode[2] = 1;
    b0 = sent_words[0];
    fork
      send_pkt(0, 5, 2, 8, 0);
    join_none
    repeat (15) @(negedge clk);
    check(in_ready[0] === 1'b0, "R8", "ready low when full", longint'(in_ready[0]), 0);
    check(sent_words[0] - b0 == DEPTH, "R8", "words accepted", sent_words[0] - b0, DEPTH);
    rdy_mode[2] = 0;
    wait fork;
    drain();

    // R9 R10: east walled
    wall[2] = 1'b1;
    b0 = words_seen[2];
    b1 = irq_cnt[4];
    send_pkt(0, 6, 1, 3, 1);
    send_pkt(0, 0, 2, 2, 0);
    drain();
    send_pkt(1, 5, 5, 2, 1);
    drain();
    check(words_seen[2] == b0, "R9", "words on walled east", words_seen[2] - b0, 0);
    check(irq_cnt[2] == irq_exp[2], "R10", "east irq cycles", irq_cnt[2], irq_exp[2]);
    check(irq_cnt[4] == b1, "R10", "west irq cycles", irq_cnt[4] - b1, 0);
    wall[2] = 1'b0;
    send_pkt(0, 4, 2, 1, 0);
    drain();

    // R11: wall raised on north after the header has been routed
    rdy_mode[1] = 2;
    b0 = irq_cnt[1];
    fork
      send_pkt(0, 2, 6, 12, 0);
    join_none
    repeat (4) @(negedge clk);
    wall[1] = 1'b1;
    wait fork;
    drain();
    wall[1] = 1'b0;
    rdy_mode[1] = 0;
    check(irq_cnt[1] == b0, "R11", "north irq", irq_cnt[1] - b0, 0);
    check(exp_q[0*NP+1].size() == 0, "R11", "north words left", exp_q[0*NP+1].size(), 0);

    for (int q = 0; q < NP*NP; q++)
      check(exp_q[q].size() == 0, "R4", "undelivered words", exp_q[q].size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule